// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Decoder with Bubble Suppression

This block turns the latched comparator bank of a flash converter into a binary sample. The 2^N-1 comparator outputs arrive as a thermometer word in which each bit reports whether the input sits above one reference level. A row-select stage finds the top edge of the thermometer and asserts one row line per code level. An encoder then ORs together the index bits of every asserted row, which is what a ROM addressed by those row lines would return.

The default row select examines a three-level window above each level. A row fires only when its own level is high and the next two levels are both low. One zero caught inside the run of ones (a bubble) therefore cannot open a second row. A parameter swaps in the plain two-level edge detect, so that its failure mode can be compared with the window. The block has one register on the comparator side and one on the code side. It raises a fault bit whenever the row lines are not exactly one-hot.

Top module: `flash_thermo_decoder`

## Requirements
- R1: A synchronous active-low reset, sampled on the rising clock edge, clears the code output and the fault output to 0.
- R2: Input bit j-1 carries reference level j. A perfect thermometer word holding k ones in levels 1..k produces code k with fault 0. The word is sampled on one rising edge and the result appears after the following rising edge: two cycles of latency.
- R3: Level 0 is taken as 1 and the levels above 2^N-1 are taken as 0. An all-zero input word therefore gives code 0, and an all-one input word gives code 2^N-1, both with fault 0.
- R4: In window mode (PLAIN_EDGE=0), a word whose top one is at level k, with a single zero at some level b (1 <= b < k), gives code k and fault 0. Two such zeros spaced three or more levels apart also give code k and fault 0.
- R5: In window mode, two adjacent zeros at levels b and b+1 with b+2 <= k select rows b-1 and k together. The code is then the bitwise OR (b-1)|k.
- R6: In plain mode (PLAIN_EDGE=1), a row fires when its level is 1 and the next level is 0. A single zero at level b below the top k gives code (b-1)|k. Perfect words still give code k.
- R7: The fault output is 1 exactly when the row lines are not one-hot. This covers the R5 and R6 cases, and it is 0 for every perfect word in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| therm_i | input | 2^N-1 | Comparator thermometer word, bit j-1 is level j |
| code_o | output | N | Registered binary code |
| fault_o | output | 1 | Registered flag: row lines not one-hot |

## Verification
The bench builds two copies with N=4 side by side. Both see every stimulus: one uses the window select and the other the plain edge detect. Fifteen levels are enough to sweep every top position k and every single-bubble position b below it, as well as adjacent and three-apart bubble pairs. Running both copies on the same words shows the window suppressing bubbles that the plain select turns into ORed multi-row codes.

// File: rtl/flash_dec_pkg.sv
// Shared helpers for the flash thermometer decoder.
// Assumes N stays small enough that 2^N-1 levels fit in an int.
package flash_dec_pkg;

    // Number of comparator levels for an N-bit converter.
    function automatic int level_count(input int n);
        return (1 << n) - 1;
    endfunction

endpackage

// File: rtl/thermo_row_select.sv
// Row-select generator: one line per code level 0..2^N-1.
// Window mode fires row m when level m is 1 and levels m+1, m+2 are 0.
// Plain mode fires row m when level m is 1 and level m+1 is 0.
// Assumes level 0 reads as 1 and levels above the top read as 0.
module thermo_row_select
    import flash_dec_pkg::*;
#(
    parameter int N          = 4,
    parameter bit PLAIN_EDGE = 1'b0
) (
    input  logic [(2**N)-2:0] therm_i,
    output logic [(2**N)-1:0] row_o
);
    localparam int LEVELS = level_count(N);

    logic [LEVELS+2:0] ext;

    // Pad the thermometer word with the implied bottom one and top zeros.
    always_comb begin
        ext               = '0;
        ext[0]            = 1'b1;
        ext[LEVELS:1]     = therm_i;
    end

    // One edge detector per level, variant chosen by parameter.
    for (genvar m = 0; m <= LEVELS; m++) begin : g_row
        if (PLAIN_EDGE) begin : g_plain
            assign row_o[m] = ext[m] & ~ext[m+1];
        end else begin : g_window
            assign row_o[m] = ext[m] & ~ext[m+1] & ~ext[m+2];
        end
    end

endmodule

// File: rtl/row_code_encoder.sv
// Stand-in for the code ROM: ORs the index bits of every asserted row line.
// Also reports when the row lines are not exactly one-hot.
module row_code_encoder
    import flash_dec_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [(2**N)-1:0] row_i,
    output logic [N-1:0]      code_o,
    output logic              fault_o
);
    localparam int LEVELS = level_count(N);

    // OR of row indices, plus detection of zero or several active rows.
    always_comb begin
        logic seen;
        logic multi;
        code_o = '0;
        seen   = 1'b0;
        multi  = 1'b0;
        for (int m = 0; m <= LEVELS; m++) begin
            if (row_i[m]) begin
                code_o = code_o | m[N-1:0];
                multi  = multi | seen;
                seen   = 1'b1;
            end
        end
        fault_o = multi | ~seen;
    end

endmodule

// File: rtl/flash_thermo_decoder.sv
// Flash converter thermometer-to-binary decoder.
// Stage 1 registers the comparator word; stage 2 registers the code and fault.
// Assumes therm_i is stable around the rising edge; reset is synchronous, active low.
module flash_thermo_decoder
    import flash_dec_pkg::*;
#(
    parameter int N          = 4,
    parameter bit PLAIN_EDGE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [(2**N)-2:0]  therm_i,
    output logic [N-1:0]       code_o,
    output logic               fault_o
);
    localparam int LEVELS = level_count(N);

    logic [LEVELS-1:0] therm_q;
    logic [LEVELS:0]   row;
    logic [N-1:0]      code_d;
    logic              fault_d;

    // Capture the comparator latches.
    always_ff @(posedge clk) begin
        if (!rst_n) therm_q <= '0;
        else        therm_q <= therm_i;
    end

    thermo_row_select #(.N(N), .PLAIN_EDGE(PLAIN_EDGE)) u_sel (
        .therm_i (therm_q),
        .row_o   (row)
    );

    row_code_encoder #(.N(N)) u_enc (
        .row_i   (row),
        .code_o  (code_d),
        .fault_o (fault_d)
    );

    // Register the decoded code and fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= '0;
            fault_o <= 1'b0;
        end else begin
            code_o  <= code_d;
            fault_o <= fault_d;
        end
    end

    // R1: reset clears outputs on the next edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && !fault_o));

    // R3: all-zero word decodes to 0.
    p_all_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_q == '0) |=> (code_o == '0 && !fault_o));

    // R3: all-one word decodes to full scale.
    p_all_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_q == '1) |=> (code_o == '1 && !fault_o));

    // R2: a perfect thermometer decodes to its count of ones.
    p_perfect_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_q & (therm_q + 1'b1)) == '0) |=>
            (int'(code_o) == $countones($past(therm_q))));

    // R7: a perfect thermometer never raises the fault.
    p_perfect_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_q & (therm_q + 1'b1)) == '0) |=> !fault_o);

endmodule

// File: tb/flash_thermo_decoder_tb.sv
// Bench: window-mode and plain-mode decoders on shared stimulus, with a
// two-deep expected-value pipeline compared on every falling edge.
module flash_thermo_decoder_tb_top;
    localparam int N  = 4;
    localparam int LV = (1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LV-1:0] therm = '0;
    logic [N-1:0]  code_w, code_p;
    logic          flt_w, flt_p;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    flash_thermo_decoder #(.N(N), .PLAIN_EDGE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .therm_i(therm), .code_o(code_w), .fault_o(flt_w));

    flash_thermo_decoder #(.N(N), .PLAIN_EDGE(1'b1)) dut_plain_i (
        .clk(clk), .rst_n(rst_n), .therm_i(therm), .code_o(code_p), .fault_o(flt_p));

    // Expected-value pipeline, index 0 newest.
    bit    pv  [2];
    int    pcw [2];
    bit    pfw [2];
    int    pcp [2];
    bit    pfp [2];
    string ptw [2];
    string ptp [2];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Word with ones at levels 1..k, zeros forced at z1 and z2 (0 = none).
    function automatic logic [LV-1:0] mk(input int k, input int z1, input int z2);
        logic [LV-1:0] v = '0;
        for (int j = 1; j <= k; j++) v[j-1] = 1'b1;
        if (z1 > 0) v[z1-1] = 1'b0;
        if (z2 > 0) v[z2-1] = 1'b0;
        return v;
    endfunction

    // One cycle: check oldest entry, shift, load new expectation, drive word.
    task automatic step(input bit vld, input logic [LV-1:0] w,
                        input int ecw, input bit efw, input string tw,
                        input int ecp, input bit efp, input string tp);
        @(negedge clk);
        if (pv[1]) begin
            chk(ptw[1], "window code", int'(code_w), pcw[1]);
            chk((ptw[1] == "R5") ? "R7" : ptw[1], "window fault", int'(flt_w), int'(pfw[1]));
            chk(ptp[1], "plain code", int'(code_p), pcp[1]);
            chk((ptp[1] == "R6") ? "R7" : ptp[1], "plain fault", int'(flt_p), int'(pfp[1]));
        end
        pv[1] = pv[0]; pcw[1] = pcw[0]; pfw[1] = pfw[0]; ptw[1] = ptw[0];
        pcp[1] = pcp[0]; pfp[1] = pfp[0]; ptp[1] = ptp[0];
        pv[0] = vld; pcw[0] = ecw; pfw[0] = efw; ptw[0] = tw;
        pcp[0] = ecp; pfp[0] = efp; ptp[0] = tp;
        therm = w;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        pv[0] = 0; pv[1] = 0;
        // R1: hold reset with a busy input; outputs must stay cleared.
        therm = '1;
        repeat (3) @(negedge clk);
        chk("R1", "reset code", int'(code_w), 0);
        chk("R1", "reset fault", int'(flt_w), 0);
        chk("R1", "reset plain code", int'(code_p), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: extremes.
        step(1, '0, 0, 0, "R3", 0, 0, "R3");
        step(1, '1, LV, 0, "R3", LV, 0, "R3");
        // R2: every perfect thermometer, both directions.
        for (int k = 0; k <= LV; k++)
            step(1, mk(k, 0, 0), k, 0, "R2", k, 0, "R2");
        for (int k = LV; k >= 0; k--)
            step(1, mk(k, 0, 0), k, 0, "R2", k, 0, "R2");
        // R4 / R6: single bubble at every position below every top.
        for (int k = 2; k <= LV; k++)
            for (int b = 1; b < k; b++)
                step(1, mk(k, b, 0), k, 0, "R4", (b-1) | k, 1, "R6");
        // R4: two bubbles three or more apart.
        for (int k = 8; k <= LV; k++)
            for (int b = 1; b + 3 < k; b++)
                step(1, mk(k, b, b+3), k, 0, "R4",
                     (b-1) | (b+2) | k, 1, "R6");
        // R5: adjacent bubble pair defeats the window.
        for (int k = 3; k <= LV; k++)
            for (int b = 1; b + 2 <= k; b++)
                step(1, mk(k, b, b+1), (b-1) | k, 1, "R5", (b-1) | k, 1, "R6");
        // Flush the pipeline.
        step(0, '0, 0, 0, "R2", 0, 0, "R2");
        step(0, '0, 0, 0, "R2", 0, 0, "R2");
        step(0, '0, 0, 0, "R2", 0, 0, "R2");
        // R1: synchronous reset mid-run clears outputs after one edge.
        therm = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-run reset code", int'(code_w), 0);
        chk("R1", "mid-run reset plain code", int'(code_p), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule